// File: doc/BRIEF.md
# GCI Link Activation Controller

This block runs the activation and deactivation handshake of a GCI link between the local controller and a layer 1 transceiver. It watches two things: whether the link bit clock is toggling, and which 4-bit command/indication (C/I) code arrives in C/I channel 0 each frame. The codes come from a separate port block that does the frame-level serialization. A code is accepted as an indication only after it has repeated across frames. When a new indication is accepted, the block raises a maskable interrupt toward the host.

A stopped line leaves the block deactivated, with its data output resting high. The layer 1 side wakes the link by restarting the bit clock and sending an indication, which moves the block to active. The host wakes the link by setting a force-to-zero control bit. That bit drives the data output low and replaces the outgoing C/I channel 0 code with the timing request (code 0). When the transceiver has answered, the host clears the bit. The block then enables normal data if the bit clock is running, or falls back to deactivated if it is not.

Top module: `gci_act_ctrl`

## Requirements
- R1: After reset the state is DEACTIVATED (`state_o` = 0), `tx_data_out` is 1, `irq` is 0 and `ind_code` holds the idle value 4'hF.
- R2: Bit clock edges move DEACTIVATED to PENDING (`state_o` = 1). From PENDING or ACTIVE, a stretch of `TIMEOUT_CYC` system clocks with no bit clock rising edge returns the block to DEACTIVATED. Shorter gaps have no effect.
- R3: A C/I code becomes the held indication (`ind_code`) only when the same code arrives on two consecutive `ci_strobe` frames and differs from the held indication. A single frame, or a repeat of the held code, leaves `ind_code` and `irq` unchanged.
- R4: A newly accepted indication while PENDING moves the block to ACTIVE (`state_o` = 3).
- R5: A new indication sets a pending flag, and `irq_ack` clears it. If both happen in the same cycle, the set wins. `irq` equals the pending flag gated by `irq_en`, and masking does not discard a pending flag.
- R6: While `force_zero` is 1, the block is in FORCE_ZERO (`state_o` = 2) from the next cycle on, from any state. In that state `tx_data_out` is 0 and `tx_ci` is 4'h0.
- R7: In FORCE_ZERO, loss of the bit clock does not change the state.
- R8: When `force_zero` is cleared in FORCE_ZERO, the block goes to ACTIVE if the bit clock is alive and to DEACTIVATED otherwise.
- R9: `tx_data_out` follows `tx_data_in` in ACTIVE and is 1 in DEACTIVATED and PENDING. Outside FORCE_ZERO, `tx_ci` equals `host_ci`.
- R10: While the bit clock is absent, the held indication returns to 4'hF and the frame history is cleared, so the first frame after a restart does not confirm a code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_clk | input | 1 | Link bit clock, asynchronous to `clk` |
| ci_strobe | input | 1 | One-cycle pulse: `rx_ci` holds this frame's C/I channel 0 code |
| rx_ci | input | 4 | Received C/I channel 0 code |
| force_zero | input | 1 | Host force-to-zero control bit |
| host_ci | input | 4 | Host command code for C/I channel 0 |
| tx_data_in | input | 1 | Normal serial data from the port block |
| irq_en | input | 1 | Interrupt enable (mask) |
| irq_ack | input | 1 | Clears the pending indication flag |
| tx_data_out | output | 1 | Data line toward layer 1 |
| tx_ci | output | 4 | C/I channel 0 code to transmit |
| state_o | output | 2 | Current state: 0 DEACT, 1 PENDING, 2 FORCE_ZERO, 3 ACTIVE |
| ind_code | output | 4 | Last accepted indication |
| irq | output | 1 | Maskable indication interrupt |

## Verification
The bench targets the following corner cases, and what a faulty design would do in each:
- Single and alternating frames, and repeats of the held code. A design with a weak confirmation filter would accept noise or raise the interrupt twice.
- Acknowledge in the same cycle as a new indication. Here the wrong priority would lose the interrupt.
- Interrupt masking. A mask that clears the pending flag would hide the interrupt for good.
- A clock gap shorter than the timeout, and one longer. An off-by-a-lot counter would drop an active link or hold a dead one.
- Force-to-zero with no bit clock. A design that applies the timeout there would abandon a host-started activation.
- The first frame after a clock restart. A design that keeps stale history across the restart would confirm a code from a single frame.

// File: rtl/gci_act_pkg.sv
package gci_act_pkg;

    localparam int CI_W = 4;
    localparam logic [CI_W-1:0] CI_IDLE = 4'hF;
    localparam logic [CI_W-1:0] CI_TIMING_REQ = 4'h0;

    typedef enum logic [1:0] {
        ST_DEACT  = 2'd0,
        ST_PEND   = 2'd1,
        ST_FZ     = 2'd2,
        ST_ACTIVE = 2'd3
    } gci_state_e;

    typedef struct packed {
        logic            valid;
        logic [CI_W-1:0] code;
    } ci_hist_t;

    function automatic logic ci_confirms(ci_hist_t hist, logic [CI_W-1:0] rx,
                                         logic [CI_W-1:0] held);
        return hist.valid && (hist.code == rx) && (rx != held);
    endfunction

    function automatic logic line_level(gci_state_e st, logic din);
        case (st)
            ST_ACTIVE: return din;
            ST_FZ:     return 1'b0;
            default:   return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/gci_clk_mon.sv
module gci_clk_mon #(
    parameter int SYNC_STAGES = 2,
    parameter int TIMEOUT_CYC = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_clk,
    output logic alive
);
    localparam int CW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC);

    logic [SYNC_STAGES:0] sync_q;
    logic [CW-1:0]        gap_q;
    logic                 rise;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-1:0], bit_clk};
    end

    assign rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

    always_ff @(posedge clk) begin
        if (rst)               gap_q <= LIMIT;
        else if (rise)         gap_q <= '0;
        else if (gap_q != LIMIT) gap_q <= gap_q + 1'b1;
    end

    assign alive = (gap_q != LIMIT);
endmodule

// File: rtl/gci_ci_filter.sv
module gci_ci_filter
    import gci_act_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            flush,
    input  logic            strobe,
    input  logic [CI_W-1:0] rx_ci,
    output logic [CI_W-1:0] held,
    output logic            fresh
);
    ci_hist_t hist_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            hist_q <= '0;
            held   <= CI_IDLE;
            fresh  <= 1'b0;
        end else begin
            fresh <= 1'b0;
            if (strobe) begin
                if (ci_confirms(hist_q, rx_ci, held)) begin
                    held  <= rx_ci;
                    fresh <= 1'b1;
                end
                hist_q <= '{valid: 1'b1, code: rx_ci};
            end
        end
    end
endmodule

// File: rtl/gci_act_ctrl.sv
module gci_act_ctrl
    import gci_act_pkg::*;
#(
    parameter int TIMEOUT_CYC = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_clk,
    input  logic       ci_strobe,
    input  logic [3:0] rx_ci,
    input  logic       force_zero,
    input  logic [3:0] host_ci,
    input  logic       tx_data_in,
    input  logic       irq_en,
    input  logic       irq_ack,
    output logic       tx_data_out,
    output logic [3:0] tx_ci,
    output logic [1:0] state_o,
    output logic [3:0] ind_code,
    output logic       irq
);
    gci_state_e state_q, state_d;
    logic       clk_alive;
    logic       ind_new;
    logic       pend_q;

    gci_clk_mon #(.SYNC_STAGES(SYNC_STAGES), .TIMEOUT_CYC(TIMEOUT_CYC)) i_mon (
        .clk(clk), .rst(rst), .bit_clk(bit_clk), .alive(clk_alive)
    );

    gci_ci_filter i_filt (
        .clk(clk), .rst(rst), .flush(~clk_alive), .strobe(ci_strobe),
        .rx_ci(rx_ci), .held(ind_code), .fresh(ind_new)
    );

    always_comb begin
        state_d = state_q;
        if (force_zero) begin
            state_d = ST_FZ;
        end else begin
            case (state_q)
                ST_DEACT:  if (clk_alive) state_d = ST_PEND;
                ST_PEND:   if (!clk_alive) state_d = ST_DEACT;
                           else if (ind_new) state_d = ST_ACTIVE;
                ST_FZ:     state_d = clk_alive ? ST_ACTIVE : ST_DEACT;
                ST_ACTIVE: if (!clk_alive) state_d = ST_DEACT;
                default:   state_d = ST_DEACT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_DEACT;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst)          pend_q <= 1'b0;
        else if (ind_new) pend_q <= 1'b1;
        else if (irq_ack) pend_q <= 1'b0;
    end

    assign irq         = pend_q & irq_en;
    assign state_o     = state_q;
    assign tx_data_out = line_level(state_q, tx_data_in);
    assign tx_ci       = (state_q == ST_FZ) ? CI_TIMING_REQ : host_ci;
endmodule

// File: rtl/gci_act_ctrl_chk.sv
module gci_act_ctrl_chk
    import gci_act_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       force_zero,
    input logic       irq_ack,
    input logic       irq_en,
    input gci_state_e state,
    input logic       clk_alive,
    input logic       ind_new,
    input logic       irq,
    input logic       tx_data_out,
    input logic [3:0] tx_ci,
    input logic [3:0] ind_code
);
    a_r2_loss_deact: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_PEND || state == ST_ACTIVE) && !clk_alive && !force_zero)
        |=> state == ST_DEACT);

    a_r4_pend_to_active: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PEND && ind_new && clk_alive && !force_zero) |=> state == ST_ACTIVE);

    a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
        (ind_new && irq_en) |=> irq);

    a_r5_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !ind_new) |=> !irq);

    a_r6_force_entry: assert property (@(posedge clk) disable iff (rst)
        force_zero |=> (state == ST_FZ && tx_ci == 4'h0 && !tx_data_out));

    a_r8_release: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FZ && !force_zero)
        |=> state == ($past(clk_alive) ? ST_ACTIVE : ST_DEACT));

    a_r9_idle_high: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DEACT || state == ST_PEND) |-> tx_data_out);

    a_r10_flush_idle: assert property (@(posedge clk) disable iff (rst)
        !clk_alive |=> ind_code == 4'hF);
endmodule

bind gci_act_ctrl gci_act_ctrl_chk i_chk (
    .clk(clk), .rst(rst), .force_zero(force_zero), .irq_ack(irq_ack),
    .irq_en(irq_en), .state(state_q), .clk_alive(clk_alive), .ind_new(ind_new),
    .irq(irq), .tx_data_out(tx_data_out), .tx_ci(tx_ci), .ind_code(ind_code)
);

// File: tb/test_gci_act_ctrl.sv
module test_gci_act_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_clk = 1'b0;
    logic       ci_strobe = 1'b0;
    logic [3:0] rx_ci = 4'h0;
    logic       force_zero = 1'b0;
    logic [3:0] host_ci = 4'h5;
    logic       tx_data_in = 1'b0;
    logic       irq_en = 1'b1;
    logic       irq_ack = 1'b0;
    logic       tx_data_out;
    logic [3:0] tx_ci;
    logic [1:0] state_o;
    logic [3:0] ind_code;
    logic       irq;
    logic       bclk_run = 1'b0;
    int         n_tests = 0;
    int         n_fail = 0;

    always #2 clk = ~clk;

    gci_act_ctrl #(.TIMEOUT_CYC(64)) i_gci_act_ctrl (
        .clk(clk), .rst(rst), .bit_clk(bit_clk), .ci_strobe(ci_strobe), .rx_ci(rx_ci),
        .force_zero(force_zero), .host_ci(host_ci), .tx_data_in(tx_data_in),
        .irq_en(irq_en), .irq_ack(irq_ack), .tx_data_out(tx_data_out), .tx_ci(tx_ci),
        .state_o(state_o), .ind_code(ind_code), .irq(irq)
    );

    initial begin
        forever begin
            repeat (4) @(negedge clk);
            if (bclk_run) bit_clk = ~bit_clk;
            else          bit_clk = 1'b0;
        end
    end

    // row: force, strobe, ci[3:0], ack, exp_state[1:0], exp_txd, exp_irq, exp_ind[3:0], pad
    localparam logic [15:0] VEC [11] = '{
        {1'b0, 1'b1, 4'hC, 1'b0, 2'd1, 1'b1, 1'b0, 4'hF, 1'b0},
        {1'b0, 1'b1, 4'hC, 1'b0, 2'd3, 1'b0, 1'b1, 4'hC, 1'b0},
        {1'b0, 1'b0, 4'h0, 1'b1, 2'd3, 1'b0, 1'b0, 4'hC, 1'b0},
        {1'b0, 1'b1, 4'hC, 1'b0, 2'd3, 1'b0, 1'b0, 4'hC, 1'b0},
        {1'b0, 1'b1, 4'h8, 1'b0, 2'd3, 1'b0, 1'b0, 4'hC, 1'b0},
        {1'b0, 1'b1, 4'hC, 1'b0, 2'd3, 1'b0, 1'b0, 4'hC, 1'b0},
        {1'b0, 1'b1, 4'hC, 1'b0, 2'd3, 1'b0, 1'b0, 4'hC, 1'b0},
        {1'b1, 1'b0, 4'h0, 1'b0, 2'd2, 1'b0, 1'b0, 4'hC, 1'b0},
        {1'b1, 1'b1, 4'h4, 1'b0, 2'd2, 1'b0, 1'b0, 4'hC, 1'b0},
        {1'b1, 1'b1, 4'h4, 1'b0, 2'd2, 1'b0, 1'b1, 4'h4, 1'b0},
        {1'b0, 1'b0, 4'h0, 1'b1, 2'd3, 1'b0, 1'b0, 4'h4, 1'b0}
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic frame(input logic [3:0] code);
        ci_strobe = 1'b1;
        rx_ci = code;
        step(1);
        ci_strobe = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        step(5);
        rst = 1'b0;
        step(1);
        chk("R1", "state", state_o, 0);
        chk("R1", "tx_data_out", tx_data_out, 1);
        chk("R1", "irq", irq, 0);
        chk("R1", "ind_code", ind_code, 15);
        step(20);
        chk("R1 no clock", "state", state_o, 0);

        bclk_run = 1'b1;
        step(20);
        chk("R2 clock start", "state", state_o, 1);
        chk("R9 pending", "tx_ci", tx_ci, 5);

        for (int i = 0; i < 11; i++) begin
            force_zero = VEC[i][15];
            ci_strobe  = VEC[i][14];
            rx_ci      = VEC[i][13:10];
            irq_ack    = VEC[i][9];
            step(1);
            ci_strobe = 1'b0;
            irq_ack   = 1'b0;
            step(3);
            chk("R3 R4 R5 R6 R8 table", "state", state_o, VEC[i][8:7]);
            chk("R6 R9 table", "tx_data_out", tx_data_out, VEC[i][6]);
            chk("R5 table", "irq", irq, VEC[i][5]);
            chk("R3 table", "ind_code", ind_code, VEC[i][4:1]);
            if (VEC[i][8:7] == 2'd2) chk("R6 table", "tx_ci", tx_ci, 0);
        end

        // R9 passthrough in ACTIVE
        tx_data_in = 1'b1;
        step(1);
        chk("R9", "tx_data_out high", tx_data_out, 1);
        tx_data_in = 1'b0;
        step(1);
        chk("R9", "tx_data_out low", tx_data_out, 0);
        chk("R9", "tx_ci host", tx_ci, 5);

        // R5 mask keeps pending
        irq_en = 1'b0;
        frame(4'h2);
        frame(4'h2);
        step(3);
        chk("R5 masked", "irq", irq, 0);
        chk("R3", "ind_code", ind_code, 2);
        irq_en = 1'b1;
        step(1);
        chk("R5 unmask", "irq", irq, 1);
        irq_ack = 1'b1;
        step(1);
        irq_ack = 1'b0;
        step(1);
        chk("R5 ack", "irq", irq, 0);

        // R5 set wins over ack
        frame(4'h6);
        ci_strobe = 1'b1;
        rx_ci = 4'h6;
        step(1);
        ci_strobe = 1'b0;
        irq_ack = 1'b1;
        step(1);
        irq_ack = 1'b0;
        step(2);
        chk("R5 set wins", "irq", irq, 1);
        irq_ack = 1'b1;
        step(1);
        irq_ack = 1'b0;

        // R2 gap shorter than timeout, then loss
        bclk_run = 1'b0;
        step(40);
        chk("R2 short gap", "state", state_o, 3);
        step(60);
        chk("R2 timeout", "state", state_o, 0);
        chk("R10 flush", "ind_code", ind_code, 15);
        chk("R9 deact", "tx_data_out", tx_data_out, 1);

        // R10 stale history after restart
        bclk_run = 1'b1;
        step(20);
        chk("R2 restart", "state", state_o, 1);
        frame(4'h6);
        step(3);
        chk("R10 single frame", "ind_code", ind_code, 15);
        chk("R10 single frame", "irq", irq, 0);
        chk("R10 single frame", "state", state_o, 1);

        // R7 / R8 force without clock
        bclk_run = 1'b0;
        step(100);
        chk("R2 loss", "state", state_o, 0);
        force_zero = 1'b1;
        step(1);
        chk("R6 from deact", "state", state_o, 2);
        chk("R6", "tx_ci", tx_ci, 0);
        chk("R6", "tx_data_out", tx_data_out, 0);
        step(150);
        chk("R7 no timeout", "state", state_o, 2);
        force_zero = 1'b0;
        step(1);
        chk("R8 release dead", "state", state_o, 0);
        chk("R9 release dead", "tx_ci", tx_ci, 5);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule